// File: doc/BRIEF.md
# XOR Chain Test Mode Controller

This block gives a chip a dedicated, non-functional test mode in which groups of input pins are folded together by XOR and driven onto an observation output. A tester holds three reset-style supply inputs high, keeps a differential test clock parked in a fixed state, and lets a timed entry window run. At the close of that window the block captures a chain number from a 4-bit active-low request bus. The test clock is then released, and from that point the selected chain's registered XOR result appears on its output.

Chain 4 is made of two sub-chains. A strap input chooses at run time how they are observed. With the strap low, each sub-chain drives its own output. With the strap high, the two results are XORed together and driven on the platform-reset output. Every other chain needs the strap high to produce a result. Which pins belong to which chain is set by parameters.

The entry sequence is a five-state machine. ST_IDLE is held while any supply input is low. It moves to ST_LONG_RUN once all three supply inputs are high. ST_LONG_RUN lasts LONG_CYC held cycles and then moves to ST_SHORT_RUN. ST_SHORT_RUN lasts SHORT_CYC held cycles and then moves to ST_GATE, and the chain select is latched on that transition. ST_GATE moves to ST_ACTIVE when the test clock toggles. If the test clock leaves its parked state during either run phase, the machine returns to the start of ST_LONG_RUN. Any supply input going low returns the machine to ST_IDLE from every state.

Top module: `xorchain_tmc`

## Requirements
- R1: The differential test clock is parked when dclk_p=0 and dclk_n=1, and it counts as toggled when dclk_p=1 and dclk_n=0. test_active rises on the first rising edge at which the test clock reads toggled after 123 parked edges have been seen since all three supply inputs went high. It does not rise earlier.
- R2: If the test clock is not parked on an edge during either run phase, the long run phase restarts from zero. This includes reading it toggled before the short phase has ended, which restarts entry instead of completing it.
- R3: The 4-bit value on req_n at the end of the short run selects the chain. A value of 0 selects chain 1, 1 selects chain 2, 2 selects chain 3, 3 selects chain 4 and 4 selects chain 5. Chain k is reported on chain_out bit k-1.
- R4: Each chain's result is the XOR of its member pins, held in a register. After each rising edge, the outputs show the pins as they were sampled at that edge.
- R5: With chain 4 selected and lan_strap low, chain_out[3] carries the XOR of sub-chain A, sub4b_out carries the XOR of sub-chain B, and plt_rst_out is 0.
- R6: With chain 4 selected and lan_strap high, plt_rst_out carries the XOR of both sub-chains combined, and both chain_out[3] and sub4b_out are 0.
- R7: With any chain other than 4 selected and lan_strap low, every XOR output is 0.
- R8: Request values 5 through 15 select no chain. Entry still completes, but every XOR output stays 0.
- R9: Changes on req_n after the select has been latched have no effect until the next entry sequence.
- R10: If any one of rsm_rst_n, pwr_good or rtc_rst_n is low at a rising edge, test_active and every XOR output are 0 after that edge. When all three return high, entry starts over from the beginning.
- R11: Whenever test_active is 0, every XOR output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock for all registers |
| rsm_rst_n | input | 1 | Resume-domain reset; must stay high during the test |
| pwr_good | input | 1 | Power-good indication; must stay high during the test |
| rtc_rst_n | input | 1 | Real-time-clock well reset; must stay high during the test |
| dclk_p | input | 1 | Positive leg of the differential test clock, sampled as data |
| dclk_n | input | 1 | Negative leg of the differential test clock, sampled as data |
| req_n | input | 4 | Active-low request bus that carries the chain-select code |
| lan_strap | input | 1 | Strap that merges (high) or splits (low) the chain 4 sub-chains |
| pins | input | 16 | Input pins observed by the chains |
| test_active | output | 1 | High while XOR outputs are enabled |
| chain_out | output | 5 | Registered result for each chain; bit k-1 belongs to chain k |
| sub4b_out | output | 1 | Registered result of chain 4 sub-chain B when split |
| plt_rst_out | output | 1 | Platform-reset pin carrying the merged chain 4 result |

## Verification
The hardest condition to reach from the ports is the exact edge of the entry window. The design has to tell a toggle that arrives one edge too early, which must restart entry, from one that arrives just in time. A disturbance of the parked clock partway through the long run must also be reset out completely. The stimulus counts edges from the moment the supply inputs go high. It releases the clock after 122 parked edges, then after 123, and in a third run inserts a one-cycle glitch, so that a design without the restart would already be active. The remaining tests walk a table of select codes, strap settings and pin patterns, with expected outputs worked out by hand from the member masks.

// File: rtl/xct_pkg.sv
package xct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LONG_RUN  = 3'd1,
        ST_SHORT_RUN = 3'd2,
        ST_GATE      = 3'd3,
        ST_ACTIVE    = 3'd4
    } entry_st_e;

endpackage

// File: rtl/xct_entry_fsm.sv
module xct_entry_fsm
    import xct_pkg::*;
#(
    parameter int LONG_CYC  = 120,
    parameter int SHORT_CYC = 2
) (
    input  logic      clk,
    input  logic      rails_ok,
    input  logic      dclk_p,
    input  logic      dclk_n,
    output entry_st_e state_q,
    output logic      latch_sel,
    output logic      enter_active
);

    localparam int MAXCYC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CNTW   = $clog2(MAXCYC + 1);
    localparam logic [CNTW-1:0] LONG_LAST  = CNTW'(LONG_CYC - 1);
    localparam logic [CNTW-1:0] SHORT_LAST = CNTW'(SHORT_CYC - 1);

    entry_st_e       state_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic            parked, toggled;

    assign parked  = !dclk_p && dclk_n;
    assign toggled = dclk_p && !dclk_n;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_LONG_RUN;
                cnt_d   = '0;
            end
            ST_LONG_RUN: begin
                if (!parked) begin
                    cnt_d = '0;
                end else if (cnt_q == LONG_LAST) begin
                    state_d = ST_SHORT_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SHORT_RUN: begin
                if (!parked) begin
                    state_d = ST_LONG_RUN;
                    cnt_d   = '0;
                end else if (cnt_q == SHORT_LAST) begin
                    state_d = ST_GATE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_GATE: begin
                if (toggled) begin
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                state_d = ST_ACTIVE;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rails_ok) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        latch_sel    = rails_ok && (state_q == ST_SHORT_RUN) && (state_d == ST_GATE);
        enter_active = rails_ok && (state_d == ST_ACTIVE);
    end

endmodule

// File: rtl/xct_sel_latch.sv
module xct_sel_latch #(
    parameter int REQW   = 4,
    parameter int NCHAIN = 5,
    parameter int SELW   = 3
) (
    input  logic            clk,
    input  logic            rails_ok,
    input  logic            latch_en,
    input  logic [REQW-1:0] req_n,
    output logic            sel_valid,
    output logic [SELW-1:0] sel_idx
);

    logic            dec_valid;
    logic [SELW-1:0] dec_idx;

    always_comb begin
        dec_valid = (req_n < REQW'(NCHAIN));
        dec_idx   = dec_valid ? SELW'(req_n) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rails_ok) begin
            sel_valid <= 1'b0;
            sel_idx   <= '0;
        end else if (latch_en) begin
            sel_valid <= dec_valid;
            sel_idx   <= dec_idx;
        end
    end

endmodule

// File: rtl/xct_xor_array.sv
module xct_xor_array #(
    parameter int NPIN      = 16,
    parameter int NCHAIN    = 5,
    parameter int SPLIT_IDX = 3,
    parameter int SELW      = 3,
    parameter logic [NCHAIN-1:0][NPIN-1:0] CHAIN_MASK = '0,
    parameter logic [NPIN-1:0] SUB_MASK = '0
) (
    input  logic              clk,
    input  logic              rails_ok,
    input  logic              enable,
    input  logic              sel_valid,
    input  logic [SELW-1:0]   sel_idx,
    input  logic              lan_strap,
    input  logic [NPIN-1:0]   pins,
    output logic [NCHAIN-1:0] chain_q,
    output logic              sub_b_q,
    output logic              merged_q
);

    logic [NCHAIN-1:0] red;
    logic [NCHAIN-1:0] chain_d;
    logic              red_b;
    logic              split_hit;
    logic              sub_b_d, merged_d;

    assign red_b     = ^(pins & SUB_MASK);
    assign split_hit = enable && sel_valid && (int'(sel_idx) == SPLIT_IDX);

    for (genvar k = 0; k < NCHAIN; k++) begin : g_chain
        assign red[k] = ^(pins & CHAIN_MASK[k]);
        if (k == SPLIT_IDX) begin : g_split
            assign chain_d[k] = split_hit && !lan_strap && red[k];
        end else begin : g_plain
            assign chain_d[k] = enable && sel_valid && (int'(sel_idx) == k)
                                && lan_strap && red[k];
        end
    end

    assign sub_b_d  = split_hit && !lan_strap && red_b;
    assign merged_d = split_hit && lan_strap && (red[SPLIT_IDX] ^ red_b);

    always_ff @(posedge clk) begin
        if (!rails_ok) begin
            chain_q  <= '0;
            sub_b_q  <= 1'b0;
            merged_q <= 1'b0;
        end else begin
            chain_q  <= chain_d;
            sub_b_q  <= sub_b_d;
            merged_q <= merged_d;
        end
    end

endmodule

// File: rtl/xorchain_tmc.sv
module xorchain_tmc
    import xct_pkg::*;
#(
    parameter int NPIN      = 16,
    parameter int NCHAIN    = 5,
    parameter int SPLIT_IDX = 3,
    parameter int REQW      = 4,
    parameter int LONG_CYC  = 120,
    parameter int SHORT_CYC = 2,
    parameter logic [NCHAIN-1:0][NPIN-1:0] CHAIN_MASK =
        {16'hFFFF, 16'h3000, 16'h0F00, 16'h00F0, 16'h000F},
    parameter logic [NPIN-1:0] SUB_MASK = 16'hC000
) (
    input  logic              clk,
    input  logic              rsm_rst_n,
    input  logic              pwr_good,
    input  logic              rtc_rst_n,
    input  logic              dclk_p,
    input  logic              dclk_n,
    input  logic [REQW-1:0]   req_n,
    input  logic              lan_strap,
    input  logic [NPIN-1:0]   pins,
    output logic              test_active,
    output logic [NCHAIN-1:0] chain_out,
    output logic              sub4b_out,
    output logic              plt_rst_out
);

    localparam int SELW = (NCHAIN > 1) ? $clog2(NCHAIN) : 1;

    logic            rails_ok;
    entry_st_e       state_q;
    logic            latch_sel;
    logic            enter_active;
    logic            sel_valid;
    logic [SELW-1:0] sel_idx;

    assign rails_ok = rsm_rst_n && pwr_good && rtc_rst_n;

    xct_entry_fsm #(
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) u_fsm (
        .clk          (clk),
        .rails_ok     (rails_ok),
        .dclk_p       (dclk_p),
        .dclk_n       (dclk_n),
        .state_q      (state_q),
        .latch_sel    (latch_sel),
        .enter_active (enter_active)
    );

    xct_sel_latch #(
        .REQW   (REQW),
        .NCHAIN (NCHAIN),
        .SELW   (SELW)
    ) u_sel (
        .clk       (clk),
        .rails_ok  (rails_ok),
        .latch_en  (latch_sel),
        .req_n     (req_n),
        .sel_valid (sel_valid),
        .sel_idx   (sel_idx)
    );

    xct_xor_array #(
        .NPIN       (NPIN),
        .NCHAIN     (NCHAIN),
        .SPLIT_IDX  (SPLIT_IDX),
        .SELW       (SELW),
        .CHAIN_MASK (CHAIN_MASK),
        .SUB_MASK   (SUB_MASK)
    ) u_xor (
        .clk       (clk),
        .rails_ok  (rails_ok),
        .enable    (enter_active),
        .sel_valid (sel_valid),
        .sel_idx   (sel_idx),
        .lan_strap (lan_strap),
        .pins      (pins),
        .chain_q   (chain_out),
        .sub_b_q   (sub4b_out),
        .merged_q  (plt_rst_out)
    );

    assign test_active = (state_q == ST_ACTIVE);

endmodule

// File: rtl/xct_checker.sv
module xct_checker #(
    parameter int NPIN      = 16,
    parameter int NCHAIN    = 5,
    parameter int SPLIT_IDX = 3,
    parameter int SELW      = 3,
    parameter logic [NCHAIN-1:0][NPIN-1:0] CHAIN_MASK = '0,
    parameter logic [NPIN-1:0] SUB_MASK = '0
) (
    input logic              clk,
    input logic              rails_ok,
    input logic              dclk_p,
    input logic              dclk_n,
    input logic              lan_strap,
    input logic [NPIN-1:0]   pins,
    input logic              test_active,
    input logic [NCHAIN-1:0] chain_out,
    input logic              sub4b_out,
    input logic              plt_rst_out,
    input logic              sel_valid,
    input logic [SELW-1:0]   sel_idx
);

    logic [NCHAIN+1:0] out_bus;
    assign out_bus = {plt_rst_out, sub4b_out, chain_out};

    // R10: a low supply input clears the mode at the next edge
    a_r10_rail_drop: assert property (@(posedge clk)
        !rails_ok |=> (!test_active && out_bus == '0));

    // R11: no output activity outside the mode
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rails_ok)
        !test_active |-> out_bus == '0);

    // R1: the mode only starts on a toggled test clock
    a_r1_entry_toggle: assert property (@(posedge clk) disable iff (!rails_ok)
        $rose(test_active) |-> $past(dclk_p && !dclk_n));

    // R9: latched select stays put while active
    a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rails_ok)
        (test_active && $past(test_active)) |-> ($stable(sel_idx) && $stable(sel_valid)));

    // R6: merged chain 4 on the platform-reset output
    a_r6_merge: assert property (@(posedge clk) disable iff (!rails_ok)
        (test_active && $past(test_active)
         && $past(sel_valid && int'(sel_idx) == SPLIT_IDX && lan_strap))
        |-> (plt_rst_out == ^($past(pins) & (CHAIN_MASK[SPLIT_IDX] | SUB_MASK))
             && !chain_out[SPLIT_IDX] && !sub4b_out));

    // R5: split chain 4 on two outputs
    a_r5_split: assert property (@(posedge clk) disable iff (!rails_ok)
        (test_active && $past(test_active)
         && $past(sel_valid && int'(sel_idx) == SPLIT_IDX && !lan_strap))
        |-> (chain_out[SPLIT_IDX] == ^($past(pins) & CHAIN_MASK[SPLIT_IDX])
             && sub4b_out == ^($past(pins) & SUB_MASK) && !plt_rst_out));

    // R7: strap low blocks every other chain
    a_r7_strap_low: assert property (@(posedge clk) disable iff (!rails_ok)
        ($past(test_active) && $past(int'(sel_idx) != SPLIT_IDX && !lan_strap))
        |-> out_bus == '0);

endmodule

bind xorchain_tmc xct_checker #(
    .NPIN       (NPIN),
    .NCHAIN     (NCHAIN),
    .SPLIT_IDX  (SPLIT_IDX),
    .SELW       (SELW),
    .CHAIN_MASK (CHAIN_MASK),
    .SUB_MASK   (SUB_MASK)
) u_chk (
    .clk         (clk),
    .rails_ok    (rails_ok),
    .dclk_p      (dclk_p),
    .dclk_n      (dclk_n),
    .lan_strap   (lan_strap),
    .pins        (pins),
    .test_active (test_active),
    .chain_out   (chain_out),
    .sub4b_out   (sub4b_out),
    .plt_rst_out (plt_rst_out),
    .sel_valid   (sel_valid),
    .sel_idx     (sel_idx)
);

// File: tb/xorchain_tmc_test.sv
module xorchain_tmc_test;

    logic        clk = 1'b0;
    logic        rsm_rst_n = 1'b0, pwr_good = 1'b0, rtc_rst_n = 1'b0;
    logic        dclk_p = 1'b0, dclk_n = 1'b1;
    logic [3:0]  req_n = 4'h0;
    logic        lan_strap = 1'b1;
    logic [15:0] pins = 16'h0000;
    logic        test_active;
    logic [4:0]  chain_out;
    logic        sub4b_out, plt_rst_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xorchain_tmc uut (
        .clk(clk), .rsm_rst_n(rsm_rst_n), .pwr_good(pwr_good), .rtc_rst_n(rtc_rst_n),
        .dclk_p(dclk_p), .dclk_n(dclk_n), .req_n(req_n), .lan_strap(lan_strap),
        .pins(pins), .test_active(test_active), .chain_out(chain_out),
        .sub4b_out(sub4b_out), .plt_rst_out(plt_rst_out)
    );

    // {code, strap, pins, chain_out, sub4b_out, plt_rst_out}
    localparam int NVEC = 12;
    localparam logic [27:0] VEC [NVEC] = '{
        {4'h0, 1'b1, 16'h0007, 5'b00001, 1'b0, 1'b0},  // R3 R4 chain 1 odd
        {4'h0, 1'b1, 16'hFFF3, 5'b00000, 1'b0, 1'b0},  // R4 chain 1 even
        {4'h1, 1'b1, 16'h0010, 5'b00010, 1'b0, 1'b0},  // R3 chain 2
        {4'h2, 1'b1, 16'h0B00, 5'b00100, 1'b0, 1'b0},  // R3 chain 3
        {4'h3, 1'b0, 16'h7000, 5'b00000, 1'b1, 1'b0},  // R5 split, B odd
        {4'h3, 1'b0, 16'h1000, 5'b01000, 1'b0, 1'b0},  // R5 split, A odd
        {4'h3, 1'b1, 16'h7000, 5'b00000, 1'b0, 1'b1},  // R6 merged odd
        {4'h3, 1'b1, 16'hF000, 5'b00000, 1'b0, 1'b0},  // R6 merged even
        {4'h4, 1'b1, 16'h8423, 5'b10000, 1'b0, 1'b0},  // R3 chain 5
        {4'h5, 1'b1, 16'hFFFF, 5'b00000, 1'b0, 1'b0},  // R8 code 5
        {4'hF, 1'b1, 16'h0001, 5'b00000, 1'b0, 1'b0},  // R8 code 15
        {4'h0, 1'b0, 16'h0007, 5'b00000, 1'b0, 1'b0}   // R7 strap low
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] obs();
        return {chain_out, sub4b_out, plt_rst_out};
    endfunction

    task automatic rails(logic v);
        rsm_rst_n = v;
        pwr_good  = v;
        rtc_rst_n = v;
    endtask

    // entry: supply low for one edge, then hold parked for nhold edges, then toggle
    task automatic enter(logic [3:0] code, logic strap, logic [15:0] pv, int nhold);
        rails(1'b0);
        dclk_p = 1'b0;
        dclk_n = 1'b1;
        tick();
        req_n     = code;
        lan_strap = strap;
        pins      = pv;
        rails(1'b1);
        repeat (nhold) tick();
        dclk_p = 1'b1;
        dclk_n = 1'b0;
        tick();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // reset state: R10 R11
        tick();
        tick();
        check("R10 reset active", 32'(test_active), 32'd0);
        check("R11 reset outputs", 32'(obs()), 32'd0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            enter(VEC[i][27:24], VEC[i][23], VEC[i][22:7], 130);
            check($sformatf("R3 vec%0d active", i), 32'(test_active), 32'd1);
            check($sformatf("R4 vec%0d outputs", i), 32'(obs()), 32'(VEC[i][6:0]));
        end

        // R1 boundary: 123 parked edges suffice
        enter(4'h0, 1'b1, 16'h0001, 123);
        check("R1 exact entry", 32'(test_active), 32'd1);

        // R2 boundary: toggle one edge early restarts entry
        enter(4'h0, 1'b1, 16'h0001, 122);
        check("R2 early toggle", 32'(test_active), 32'd0);
        repeat (5) tick();
        check("R2 early toggle stays out", 32'(test_active), 32'd0);
        check("R11 outputs while out", 32'(obs()), 32'd0);

        // R2 glitch mid long run
        rails(1'b0);
        dclk_p = 1'b0; dclk_n = 1'b1;
        tick();
        rails(1'b1);
        repeat (60) tick();
        dclk_p = 1'b1; dclk_n = 1'b1;
        tick();
        dclk_p = 1'b0; dclk_n = 1'b1;
        repeat (100) tick();
        dclk_p = 1'b1; dclk_n = 1'b0;
        tick();
        check("R2 glitch restart", 32'(test_active), 32'd0);
        dclk_p = 1'b0; dclk_n = 1'b1;
        repeat (130) tick();
        dclk_p = 1'b1; dclk_n = 1'b0;
        tick();
        check("R2 entry after glitch", 32'(test_active), 32'd1);

        // R9: request changes ignored after latch
        enter(4'h0, 1'b1, 16'h0011, 130);
        req_n = 4'h1;
        tick();
        tick();
        check("R9 select held", 32'(obs()), 32'({5'b00001, 2'b00}));

        // R4 registered timing
        pins = 16'h0000;
        #1;
        check("R4 before edge", 32'(obs()), 32'({5'b00001, 2'b00}));
        tick();
        check("R4 after edge", 32'(obs()), 32'd0);

        // R10 each supply input alone
        pins = 16'h0001;
        tick();
        pwr_good = 1'b0;
        tick();
        check("R10 power good drop", 32'({test_active, obs()}), 32'd0);
        pwr_good = 1'b1;
        tick();
        tick();
        check("R10 restart needed", 32'(test_active), 32'd0);

        enter(4'h0, 1'b1, 16'h0001, 130);
        rtc_rst_n = 1'b0;
        tick();
        check("R10 rtc drop", 32'({test_active, obs()}), 32'd0);
        rtc_rst_n = 1'b1;

        enter(4'h0, 1'b1, 16'h0001, 130);
        rsm_rst_n = 1'b0;
        tick();
        check("R10 resume drop", 32'({test_active, obs()}), 32'd0);
        rsm_rst_n = 1'b1;

        // R5 R6: strap flips live on chain 4
        enter(4'h3, 1'b0, 16'h1000, 130);
        check("R5 split A", 32'(obs()), 32'({5'b01000, 2'b00}));
        lan_strap = 1'b1;
        tick();
        check("R6 merged after flip", 32'(obs()), 32'({5'b00000, 2'b01}));

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule